// File: doc/BRIEF.md
# I2C Interrupt Status and Mask Unit

This unit sits beside an I2C controller core and turns the core's single-cycle event pulses into sticky interrupt status that a CPU can read, mask and clear through a small register port. Six events are tracked: general call received, START/RESTART seen, STOP seen, bus activity, slave-transmit done (master did not acknowledge the final byte), and transmit abort. A mask register selects which sticky bits reach a single registered interrupt line.

Each status bit has its own clear address. A read there returns the old bit value and clears the bit. A global clear address wipes every bit at once. Dropping the controller enable clears everything and keeps it clear. A transmit abort also raises a hold that keeps the TX FIFO flushed until software clears the abort bit.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After a synchronous reset the mask field reads 0x8C0 at address 0: general call, rx-done and tx-abort are enabled, the others are disabled. Raw status is 0, and `irq` and `tx_flush_hold` are 0.
- R2: `evt_pulse` bit order is bit 5 general call, 4 start, 3 stop, 2 activity, 1 rx-done, 0 tx-abort. A pulse while enabled sets the matching sticky raw bit on the next clock edge. The bit stays set until something clears it. Address 1 reads raw status in bits 11..6, in the same order from bit 11 down.
- R3: Address 0 is the read/write mask. Bits 11..6 follow the R2 order, and bits 5..0 read as 0.
- R4: Address 2 reads raw AND mask in bits 11..6.
- R5: `irq` is registered. In each cycle it equals the OR of the masked bits in the previous cycle.
- R6: The dedicated clear addresses are 4 (general call), 5 (start), 6 (stop), 7 (activity), 8 (rx-done) and 9 (tx-abort). A read there returns the bit's current value in bit 0 and clears only that bit on the following edge.
- R7: A read of address 3 returns the OR of all raw bits in bit 0 and clears every raw bit on the following edge.
- R8: An event pulse in the same cycle as a clear of its bit, dedicated or global, leaves the bit set.
- R9: While `ctrl_enable` is low, all raw bits clear on the next edge and stay clear, and event pulses are ignored.
- R10: `tx_flush_hold` is high exactly while the tx-abort raw bit is set. It is released only by a clear at address 9, a clear at address 3, a disable or a reset.
- R11: Reads of addresses 0, 1 and 2 change no state. Writes to any address other than 0 change no state. Unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_enable | input | 1 | Controller enabled; low clears and holds all status |
| evt_pulse | input | 6 | Event pulses from the controller core |
| reg_rd | input | 1 | Read strobe; at a clear address it clears |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined registered interrupt |
| tx_flush_hold | output | 1 | Holds the TX FIFO flushed |

## Verification
The hardest case to reach from the ports is a collision at one clock edge: an event pulse lands in the same cycle as a clear of its own bit, or as a global clear, or while the enable drops. Directed sequences set up each of these collisions on purpose. Constrained random traffic then keeps events dense enough, at about one in eight per bit per cycle, that they collide with clear reads and disables many times over. A bench model tracks the raw bits, the mask and the registered `irq`, and predicts the read data at every address.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int unsigned EVT_N     = 6;
    localparam int unsigned FIELD_LSB = 6;
    localparam int unsigned REG_W     = FIELD_LSB + EVT_N;
    localparam int unsigned ADDR_W    = 4;

    // event index inside the status vector (bit FIELD_LSB+idx in registers)
    localparam int unsigned EV_TXABT  = 0;
    localparam int unsigned EV_RXDONE = 1;
    localparam int unsigned EV_ACT    = 2;
    localparam int unsigned EV_STOP   = 3;
    localparam int unsigned EV_START  = 4;
    localparam int unsigned EV_GCALL  = 5;

    localparam logic [EVT_N-1:0] MASK_RST = 6'b100011;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK      = 4'd0,
        A_RAW       = 4'd1,
        A_MASKED    = 4'd2,
        A_CLR_ALL   = 4'd3,
        A_CLR_GCALL = 4'd4,
        A_CLR_START = 4'd5,
        A_CLR_STOP  = 4'd6,
        A_CLR_ACT   = 4'd7,
        A_CLR_RXD   = 4'd8,
        A_CLR_TXABT = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } bus_req_t;

    // dedicated clear address for event index idx
    function automatic logic [ADDR_W-1:0] clr_addr(input int unsigned idx);
        return ADDR_W'(int'(A_CLR_TXABT) - int'(idx));
    endfunction

    function automatic logic [REG_W-1:0] place_field(input logic [EVT_N-1:0] v);
        return REG_W'(v) << FIELD_LSB;
    endfunction

endpackage

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst || !enable) q <= 1'b0;
        else if (set_i)     q <= 1'b1;   // event wins over clear
        else if (clr_i)     q <= 1'b0;
    end

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (enable && set_i) |=> q);
    a_r2_holds: assert property (@(posedge clk) disable iff (rst)
        (enable && q && !clr_i) |=> q);
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (enable && clr_i && !set_i) |=> !q);
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !q);

endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
    import i2c_irq_pkg::*;
#(
    parameter logic [EVT_N-1:0] MASK_RESET = MASK_RST
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [EVT_N-1:0] raw,
    output logic [EVT_N-1:0] mask,
    output logic [EVT_N-1:0] clr_vec,
    output logic [REG_W-1:0] rdata
);

    logic             clr_all;
    logic [REG_W-1:0] unused_wdata;

    assign unused_wdata = req.wdata;
    assign clr_all      = req.rd && (req.addr == A_CLR_ALL);

    always_ff @(posedge clk) begin
        if (rst) mask <= MASK_RESET;
        else if (req.wr && req.addr == A_MASK)
            mask <= req.wdata[FIELD_LSB +: EVT_N];
    end

    for (genvar i = 0; i < EVT_N; i++) begin : g_clr
        assign clr_vec[i] = clr_all || (req.rd && req.addr == clr_addr(i));
    end

    always_comb begin
        rdata = '0;
        case (req.addr)
            A_MASK:    rdata = place_field(mask);
            A_RAW:     rdata = place_field(raw);
            A_MASKED:  rdata = place_field(raw & mask);
            A_CLR_ALL: rdata = REG_W'(|raw);
            default: begin
                for (int unsigned k = 0; k < EVT_N; k++)
                    if (req.addr == clr_addr(k)) rdata = REG_W'(raw[k]);
            end
        endcase
    end

    a_r1_mask_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == MASK_RESET));
    a_r3_mask_write: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.addr == A_MASK) |=> (mask == $past(req.wdata[FIELD_LSB +: EVT_N])));
    a_r11_mask_stable: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == A_MASK) |=> $stable(mask));

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
#(
    parameter logic [EVT_N-1:0] MASK_RESET = MASK_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_enable,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              tx_flush_hold
);

    bus_req_t         req;
    logic [EVT_N-1:0] raw, mask, clr_vec, masked;

    assign req = '{rd: reg_rd, wr: reg_wr, addr: reg_addr, wdata: reg_wdata};

    i2c_irq_regif #(.MASK_RESET(MASK_RESET)) u_regif (
        .clk(clk), .rst(rst), .req(req), .raw(raw),
        .mask(mask), .clr_vec(clr_vec), .rdata(reg_rdata)
    );

    for (genvar i = 0; i < EVT_N; i++) begin : g_bit
        i2c_irq_sticky u_bit (
            .clk(clk), .rst(rst), .enable(ctrl_enable),
            .set_i(evt_pulse[i]), .clr_i(clr_vec[i]), .q(raw[i])
        );
    end

    assign masked = raw & mask;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |masked;
    end

    assign tx_flush_hold = raw[EV_TXABT];

    a_r5_irq_registered: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|masked)));
    a_r10_hold_rises: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_flush_hold) |-> $past(evt_pulse[EV_TXABT] && ctrl_enable));
    a_r10_hold_falls: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_flush_hold) |-> $past(clr_vec[EV_TXABT] || !ctrl_enable));
    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
        (ctrl_enable && evt_pulse[EV_TXABT] && clr_vec[EV_TXABT]) |=> tx_flush_hold);

endmodule

// File: tb/sim_i2c_irq_ctrl.sv
module sim_i2c_irq_ctrl;
    import i2c_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctrl_enable = 1'b1;
    logic [EVT_N-1:0]  evt_pulse = '0;
    logic              reg_rd = 1'b0, reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq, tx_flush_hold;

    int  checks = 0, fails = 0;
    bit  done = 1'b0;
    logic [EVT_N-1:0] m_raw = '0, m_mask = MASK_RST;
    logic             m_irq = 1'b0;

    always #5 clk = ~clk;

    i2c_irq_ctrl u0 (
        .clk(clk), .rst(rst), .ctrl_enable(ctrl_enable), .evt_pulse(evt_pulse),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .tx_flush_hold(tx_flush_hold)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [REG_W-1:0] f_rdata(input logic [ADDR_W-1:0] a,
                                                 input logic [EVT_N-1:0] raw,
                                                 input logic [EVT_N-1:0] msk);
        if (a == 0) return REG_W'(msk) << FIELD_LSB;
        if (a == 1) return REG_W'(raw) << FIELD_LSB;
        if (a == 2) return REG_W'(raw & msk) << FIELD_LSB;
        if (a == 3) return REG_W'(|raw);
        if (a >= 4 && a <= 9) return REG_W'(raw[9 - a]);
        return '0;
    endfunction

    function automatic string f_tag(input logic [ADDR_W-1:0] a);
        if (a == 0) return "R3";
        if (a == 1) return "R2";
        if (a == 2) return "R4";
        if (a == 3) return "R7";
        if (a >= 4 && a <= 9) return "R6";
        return "R11";
    endfunction

    // called just after a falling edge; returns just after the next one
    task automatic step(input logic rd, input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [REG_W-1:0] wd, input logic [EVT_N-1:0] ev,
                        input logic en, input string tag);
        logic [EVT_N-1:0] nraw;
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        evt_pulse = ev; ctrl_enable = en;
        #1;
        chk({(tag == "") ? f_tag(a) : tag, " rdata"}, 32'(reg_rdata), 32'(f_rdata(a, m_raw, m_mask)));
        chk("R5 irq", 32'(irq), 32'(m_irq));
        chk("R10 flush", 32'(tx_flush_hold), 32'(m_raw[0]));
        for (int i = 0; i < EVT_N; i++) begin
            if (!en)                                  nraw[i] = 1'b0;
            else if (ev[i])                           nraw[i] = 1'b1;
            else if (rd && (a == 3 || a == 4'(9 - i))) nraw[i] = 1'b0;
            else                                      nraw[i] = m_raw[i];
        end
        m_irq = |(m_raw & m_mask);
        if (wr && a == 0) m_mask = wd[FIELD_LSB +: EVT_N];
        m_raw = nraw;
        @(negedge clk);
    endtask

    task automatic idle_read(input logic [ADDR_W-1:0] a, input string tag);
        step(1'b0, 1'b0, a, '0, '0, 1'b1, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk("R1 mask", 32'(reg_rdata), 32'h8C0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 flush", 32'(tx_flush_hold), 32'd0);
        idle_read(4'd1, "R1");

        // R2: general call and stop set sticky bits
        step(1'b0, 1'b0, 4'd1, '0, 6'b101000, 1'b1, "R2");
        idle_read(4'd1, "R2");
        idle_read(4'd1, "R11");          // plain reads do not clear
        idle_read(4'd2, "R4");
        // R6: dedicated clear of stop returns 1, then clears
        step(1'b1, 1'b0, 4'd6, '0, '0, 1'b1, "R6");
        idle_read(4'd6, "R6");
        // R8: general call event during its own clear
        step(1'b1, 1'b0, 4'd4, '0, 6'b100000, 1'b1, "R8");
        idle_read(4'd4, "R8");
        // R10: tx abort raises hold, global clear with concurrent start
        step(1'b0, 1'b0, 4'd9, '0, 6'b000001, 1'b1, "R10");
        idle_read(4'd9, "R10");
        step(1'b1, 1'b0, 4'd3, '0, 6'b010000, 1'b1, "R7");
        idle_read(4'd1, "R7");
        step(1'b1, 1'b0, 4'd3, '0, '0, 1'b1, "R7");
        // R11: write to non-mask address, then mask
        step(1'b0, 1'b1, 4'd1, 12'hFFF, '0, 1'b1, "R11");
        idle_read(4'd0, "R11");
        step(1'b0, 1'b1, 4'd0, 12'hFFF, '0, 1'b1, "R3");
        idle_read(4'd0, "R3");
        // R9: disable clears and ignores events
        step(1'b0, 1'b0, 4'd1, '0, 6'b111111, 1'b1, "R2");
        step(1'b0, 1'b0, 4'd1, '0, 6'b111111, 1'b0, "R9");
        step(1'b0, 1'b0, 4'd1, '0, 6'b111111, 1'b0, "R9");
        idle_read(4'd1, "R9");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [EVT_N-1:0] ev;
            logic rd, wr, en;
            for (int b = 0; b < EVT_N; b++) ev[b] = ($urandom_range(7) == 0);
            rd = ($urandom_range(2) == 0);
            wr = !rd && ($urandom_range(5) == 0);
            en = ($urandom_range(39) != 0);
            step(rd, wr, 4'($urandom_range(11)), 12'($urandom), ev, en, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule